// File: doc/BRIEF.md
# Retired-Instruction Slice Builder

This block keeps a rolling record of the instructions a core retires and builds a precomputation slice from that record for one chosen load that misses often. During normal operation, each retired instruction is written into a circular buffer in program order. The record holds the instruction's PC, an optional destination register and up to two optional source registers. Once the buffer is full, the oldest record is overwritten.

When a build is requested for a target PC, capture stops. The analyser first scans backward from the newest record to find the most recent occurrence of the target. It then walks further back with a bitmask of the registers the slice still needs. Every record that writes a needed register joins the slice: its destination leaves the set and its sources enter it. The walk stops at the next older occurrence of the target, which becomes the trigger. In multi-pass mode the walk continues toward the next older occurrence, starting from the previous pass's live-ins. It stops once a pass ends with the same set it started from.

The result has three parts: a per-slot inclusion mask, the live-in register bitmask and the trigger slot. A single-cycle done or fail pulse marks the end of the build.

Top module: `ribSliceBuilder`

## Requirements
- R1: After reset the buffer is empty and the write slot is 0. Every instruction retired while capture is open goes into the next slot (slot k for the k-th capture, modulo DEPTH). With the default DEPTH of 64, records older than the newest 64 are overwritten.
- R2: Capture is closed while `busy` is high and in the cycle `buildStart` is sampled. Instructions retired then are not recorded and have no effect on any later build.
- R3: The target occurrence is always in the slice. Walking backward, a record whose destination is valid and in the needed set is included. The needed set then loses that destination and gains the valid sources. `sliceMask` bit i refers to buffer slot i.
- R4: `liveIns` bit n is set when register n is still needed at the end of the last completed pass.
- R5: `triggerIdx` is the slot of the older occurrence that ended the last completed pass.
- R6: If the first pass does not reach a second occurrence (including an empty buffer or an absent PC), `fail` pulses and `sliceMask`, `liveIns` and `triggerIdx` read zero.
- R7: With `multiPass` set, a new pass continues from the trigger toward the next older occurrence. It starts from the live-ins of the previous pass, and the mask accumulates across passes. The build ends with `done` when a pass ends with the live-in set it started from. If the buffer runs out after at least one pass, the build also ends with `done`, reporting the last completed pass.
- R8: One record is examined per clock. `done` or `fail` is a one-cycle pulse that never coincides with the other, and `busy` is high from the cycle after `buildStart` until the result. After N examined records, the result appears N cycles after the start edge, or N+1 cycles after it when the buffer runs out.
- R9: Reset clears `busy`, `done`, `fail` and all result outputs.
- R10: An invalid source bit adds nothing to the needed set. A record with an invalid destination is never included, whatever its destination field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | A retired instruction is presented |
| retirePc | input | PC_W | PC of the retired instruction |
| retireDstValid | input | 1 | Destination register field is valid |
| retireDst | input | REG_W | Destination register |
| retireSrcAValid | input | 1 | First source field is valid |
| retireSrcA | input | REG_W | First source register |
| retireSrcBValid | input | 1 | Second source field is valid |
| retireSrcB | input | REG_W | Second source register |
| buildStart | input | 1 | Start a build (sampled when not busy) |
| buildPc | input | PC_W | PC of the load to build a slice for |
| multiPass | input | 1 | Enable repeated passes until the live-ins settle |
| busy | output | 1 | Build in progress, capture frozen |
| done | output | 1 | One-cycle pulse: slice valid |
| fail | output | 1 | One-cycle pulse: no second occurrence found |
| sliceMask | output | DEPTH | Slot inclusion mask |
| liveIns | output | 2**REG_W | Live-in register bitmask |
| triggerIdx | output | log2(DEPTH) | Trigger slot |

## Verification
The result of a build is due a fixed number of clock edges after the edge that samples `buildStart`. That number equals the count of records examined: from the newest slot back to the trigger slot of the last pass, plus one edge when the build ends because the buffer ran out. The bench drives inputs and samples outputs on the falling edge. It counts rising edges from the start edge until the pulse, then compares that count with a latency worked out for each stimulus vector by walking the slot numbers by hand. It also checks that the pulse is gone one cycle later, and reads the held results only after the pulse.

// File: rtl/ribPkg.sv
package ribPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_WALK = 2'd2
  } buildStateT;

  // Strobes from the control FSM to the slice datapath.
  typedef struct packed {
    logic clearWork;   // latch target PC, clear work state and results
    logic seedTarget;  // newest occurrence found: mark it, seed the needed set
    logic stepEntry;   // examine one older record
    logic commitPass;  // pass reached an older occurrence: publish results
    logic nextPass;    // another pass follows: remember its starting set
  } sliceStrobeT;

endpackage

// File: rtl/ribStore.sv
module ribStore #(
  parameter int DEPTH = 64,
  parameter int PC_W  = 32,
  parameter int REG_W = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             freeze,
  input  logic [PC_W-1:0]  wrPc,
  input  logic             wrDstV,
  input  logic [REG_W-1:0] wrDst,
  input  logic             wrAV,
  input  logic [REG_W-1:0] wrA,
  input  logic             wrBV,
  input  logic [REG_W-1:0] wrB,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [PC_W-1:0]  rdPc,
  output logic             rdDstV,
  output logic [REG_W-1:0] rdDst,
  output logic             rdAV,
  output logic [REG_W-1:0] rdA,
  output logic             rdBV,
  output logic [REG_W-1:0] rdB,
  output logic [IDX_W-1:0] newestIdx,
  output logic [CNT_W-1:0] fillCount
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [PC_W-1:0]  pcMem  [DEPTH];
  logic             dvMem  [DEPTH];
  logic [REG_W-1:0] dstMem [DEPTH];
  logic             avMem  [DEPTH];
  logic [REG_W-1:0] aMem   [DEPTH];
  logic             bvMem  [DEPTH];
  logic [REG_W-1:0] bMem   [DEPTH];

  logic [IDX_W-1:0] wrPtr;

  always_ff @(posedge clk) begin
    if (wrEn) begin
      pcMem[wrPtr]  <= wrPc;
      dvMem[wrPtr]  <= wrDstV;
      dstMem[wrPtr] <= wrDst;
      avMem[wrPtr]  <= wrAV;
      aMem[wrPtr]   <= wrA;
      bvMem[wrPtr]  <= wrBV;
      bMem[wrPtr]   <= wrB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      fillCount <= '0;
    end else if (wrEn) begin
      wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
      if (fillCount != FULL_CNT) fillCount <= fillCount + 1'b1;
    end
  end

  assign newestIdx = (wrPtr == '0) ? LAST_SLOT : wrPtr - 1'b1;

  assign rdPc   = pcMem[rdIdx];
  assign rdDstV = dvMem[rdIdx];
  assign rdDst  = dstMem[rdIdx];
  assign rdAV   = avMem[rdIdx];
  assign rdA    = aMem[rdIdx];
  assign rdBV   = bvMem[rdIdx];
  assign rdB    = bMem[rdIdx];

  AST_NO_WRITE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> ($stable(newestIdx) && $stable(fillCount))) else $error("capture while frozen"); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= FULL_CNT) else $error("fill count overflow"); // R1

endmodule

// File: rtl/sliceControl.sv
module sliceControl
  import ribPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             buildStart,
  input  logic             multiPass,
  input  logic [IDX_W-1:0] newestIdx,
  input  logic [CNT_W-1:0] fillCount,
  input  logic             isTarget,
  input  logic             liveSame,
  output sliceStrobeT      strobe,
  output logic [IDX_W-1:0] pos,
  output logic             busy,
  output logic             done,
  output logic             fail
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);

  buildStateT       state;
  logic [CNT_W-1:0] remaining;
  logic             committed;
  logic             multiQ;
  logic [IDX_W-1:0] posPrev;
  logic             outOfEntries;

  assign outOfEntries = (remaining == '0);
  assign posPrev      = (pos == '0) ? LAST_SLOT : pos - 1'b1;
  assign busy         = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: strobe.clearWork = buildStart;
      ST_SEEK: strobe.seedTarget = !outOfEntries && isTarget;
      ST_WALK: begin
        if (!outOfEntries) begin
          if (isTarget) begin
            strobe.commitPass = 1'b1;
            strobe.nextPass   = multiQ && !liveSame;
          end else begin
            strobe.stepEntry = 1'b1;
          end
        end
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pos       <= '0;
      remaining <= '0;
      committed <= 1'b0;
      multiQ    <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (buildStart) begin
            state     <= ST_SEEK;
            pos       <= newestIdx;
            remaining <= fillCount;
            committed <= 1'b0;
            multiQ    <= multiPass;
          end
        end
        ST_SEEK: begin
          if (outOfEntries) begin
            fail  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            pos       <= posPrev;
            remaining <= remaining - 1'b1;
            if (isTarget) state <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (outOfEntries) begin
            state <= ST_IDLE;
            if (committed) done <= 1'b1;
            else           fail <= 1'b1;
          end else begin
            pos       <= posPrev;
            remaining <= remaining - 1'b1;
            if (isTarget) begin
              committed <= 1'b1;
              if (!multiQ || liveSame) begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail)) else $error("done and fail together"); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R8
  AST_IDLE_AT_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (done || fail) |-> !busy) else $error("result while busy"); // R8
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clearWork, strobe.seedTarget, strobe.stepEntry, strobe.commitPass}))
    else $error("conflicting strobes"); // R8

endmodule

// File: rtl/sliceDatapath.sv
module sliceDatapath
  import ribPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PC_W  = 32,
  parameter int REG_W = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int NREG  = 1 << REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  sliceStrobeT      strobe,
  input  logic [PC_W-1:0]  buildPc,
  input  logic [IDX_W-1:0] pos,
  input  logic [PC_W-1:0]  rdPc,
  input  logic             rdDstV,
  input  logic [REG_W-1:0] rdDst,
  input  logic             rdAV,
  input  logic [REG_W-1:0] rdA,
  input  logic             rdBV,
  input  logic [REG_W-1:0] rdB,
  output logic             isTarget,
  output logic             liveSame,
  output logic [DEPTH-1:0] sliceMask,
  output logic [NREG-1:0]  liveIns,
  output logic [IDX_W-1:0] triggerIdx
);

  logic [PC_W-1:0]  targetQ;
  logic [DEPTH-1:0] workMask;
  logic [NREG-1:0]  needed;
  logic [NREG-1:0]  passStart;
  logic [NREG-1:0]  srcBits;
  logic [NREG-1:0]  dstBit;
  logic             producesNeeded;

  always_comb begin
    srcBits = '0;
    if (rdAV) srcBits[rdA] = 1'b1;
    if (rdBV) srcBits[rdB] = 1'b1;
    dstBit = '0;
    dstBit[rdDst] = 1'b1;
  end

  assign producesNeeded = rdDstV && needed[rdDst];
  assign isTarget       = (rdPc == targetQ);
  assign liveSame       = (needed == passStart);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetQ    <= '0;
      workMask   <= '0;
      needed     <= '0;
      passStart  <= '0;
      sliceMask  <= '0;
      liveIns    <= '0;
      triggerIdx <= '0;
    end else begin
      if (strobe.clearWork) begin
        targetQ    <= buildPc;
        workMask   <= '0;
        needed     <= '0;
        passStart  <= '0;
        sliceMask  <= '0;
        liveIns    <= '0;
        triggerIdx <= '0;
      end
      if (strobe.seedTarget) begin
        workMask[pos] <= 1'b1;
        needed        <= srcBits;
        passStart     <= srcBits;
      end
      if (strobe.stepEntry && producesNeeded) begin
        workMask[pos] <= 1'b1;
        needed        <= (needed & ~dstBit) | srcBits;
      end
      if (strobe.commitPass) begin
        sliceMask  <= workMask;
        liveIns    <= needed;
        triggerIdx <= pos;
        if (strobe.nextPass) passStart <= needed;
      end
    end
  end

  AST_NEXT_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nextPass |-> strobe.commitPass) else $error("pass restart without commit"); // R7
  AST_MASK_NONEMPTY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitPass |-> (workMask != '0)) else $error("commit with empty slice"); // R3

endmodule

// File: rtl/ribSliceBuilder.sv
module ribSliceBuilder
  import ribPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PC_W  = 32,
  parameter int REG_W = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NREG  = 1 << REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retireValid,
  input  logic [PC_W-1:0]  retirePc,
  input  logic             retireDstValid,
  input  logic [REG_W-1:0] retireDst,
  input  logic             retireSrcAValid,
  input  logic [REG_W-1:0] retireSrcA,
  input  logic             retireSrcBValid,
  input  logic [REG_W-1:0] retireSrcB,
  input  logic             buildStart,
  input  logic [PC_W-1:0]  buildPc,
  input  logic             multiPass,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [DEPTH-1:0] sliceMask,
  output logic [NREG-1:0]  liveIns,
  output logic [IDX_W-1:0] triggerIdx
);

  sliceStrobeT      strobe;
  logic [IDX_W-1:0] pos;
  logic [IDX_W-1:0] newestIdx;
  logic [CNT_W-1:0] fillCount;
  logic [PC_W-1:0]  rdPc;
  logic             rdDstV, rdAV, rdBV;
  logic [REG_W-1:0] rdDst, rdA, rdB;
  logic             isTarget, liveSame;
  logic             captureEn;

  assign captureEn = retireValid && !busy && !buildStart;

  ribStore #(.DEPTH(DEPTH), .PC_W(PC_W), .REG_W(REG_W)) store_i (
    .clk(clk), .rstN(rstN), .wrEn(captureEn), .freeze(busy),
    .wrPc(retirePc), .wrDstV(retireDstValid), .wrDst(retireDst),
    .wrAV(retireSrcAValid), .wrA(retireSrcA),
    .wrBV(retireSrcBValid), .wrB(retireSrcB),
    .rdIdx(pos), .rdPc(rdPc), .rdDstV(rdDstV), .rdDst(rdDst),
    .rdAV(rdAV), .rdA(rdA), .rdBV(rdBV), .rdB(rdB),
    .newestIdx(newestIdx), .fillCount(fillCount)
  );

  sliceControl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .buildStart(buildStart), .multiPass(multiPass),
    .newestIdx(newestIdx), .fillCount(fillCount),
    .isTarget(isTarget), .liveSame(liveSame),
    .strobe(strobe), .pos(pos), .busy(busy), .done(done), .fail(fail)
  );

  sliceDatapath #(.DEPTH(DEPTH), .PC_W(PC_W), .REG_W(REG_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .buildPc(buildPc), .pos(pos),
    .rdPc(rdPc), .rdDstV(rdDstV), .rdDst(rdDst),
    .rdAV(rdAV), .rdA(rdA), .rdBV(rdBV), .rdB(rdB),
    .isTarget(isTarget), .liveSame(liveSame),
    .sliceMask(sliceMask), .liveIns(liveIns), .triggerIdx(triggerIdx)
  );

  AST_DONE_HAS_SLICE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sliceMask != '0)) else $error("done with empty mask"); // R3
  AST_FAIL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (sliceMask == '0 && liveIns == '0)) else $error("fail with results"); // R6

endmodule

// File: tb/ribSliceBuilder_tb.sv
module ribSliceBuilder_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  iters;
    logic [31:0] pc;
    logic        multi;
    logic [63:0] mask;
    logic [31:0] live;
    logic [5:0]  trig;
    logic        isFail;
    logic [7:0]  lat;
  } vecT;

  // Loop body, 9 records per iteration, PCs 0x100..0x120:
  // load r1=[r2]; r3=r3+1; r6=r3-100; r2=r2+8; r1=r4+r1; load r5=[r1];
  // r5=r5+1; store [r1]=r5; branch on r6
  localparam int NVEC = 9;
  localparam vecT VECS [NVEC] = '{
    '{8'd3, 32'h114, 1'b0, 64'h0000_0000_00C4_0000, 32'h14, 6'd14, 1'b0, 8'd13}, // R3 R4 R5
    '{8'd3, 32'h114, 1'b1, 64'h0000_0000_00C4_1000, 32'h14, 6'd5,  1'b0, 8'd22}, // R7
    '{8'd3, 32'h118, 1'b0, 64'h0000_0000_01C4_0000, 32'h14, 6'd15, 1'b0, 8'd12}, // R3
    '{8'd3, 32'h118, 1'b1, 64'h0000_0000_01C4_1000, 32'h14, 6'd6,  1'b0, 8'd21}, // R7
    '{8'd2, 32'h114, 1'b1, 64'h0000_0000_0000_6200, 32'h14, 6'd5,  1'b0, 8'd19}, // R7 run-out
    '{8'd1, 32'h114, 1'b0, 64'h0,                   32'h0,  6'd0,  1'b1, 8'd10}, // R6
    '{8'd3, 32'h150, 1'b0, 64'h0,                   32'h0,  6'd0,  1'b1, 8'd28}, // R6 absent
    '{8'd8, 32'h114, 1'b0, 64'h8000_0000_0000_0018, 32'h14, 6'd59, 1'b0, 8'd13}, // R1 wrap
    '{8'd3, 32'h100, 1'b0, 64'h0000_0000_0004_1000, 32'h4,  6'd9,  1'b0, 8'd18}  // R3
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        retireValid, retireDstValid, retireSrcAValid, retireSrcBValid;
  logic [31:0] retirePc;
  logic [4:0]  retireDst, retireSrcA, retireSrcB;
  logic        buildStart, multiPass;
  logic [31:0] buildPc;
  logic        busy, done, fail;
  logic [63:0] sliceMask;
  logic [31:0] liveIns;
  logic [5:0]  triggerIdx;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ribSliceBuilder dut_i (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .retirePc(retirePc),
    .retireDstValid(retireDstValid), .retireDst(retireDst),
    .retireSrcAValid(retireSrcAValid), .retireSrcA(retireSrcA),
    .retireSrcBValid(retireSrcBValid), .retireSrcB(retireSrcB),
    .buildStart(buildStart), .buildPc(buildPc), .multiPass(multiPass),
    .busy(busy), .done(done), .fail(fail), .sliceMask(sliceMask),
    .liveIns(liveIns), .triggerIdx(triggerIdx)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setRetire(input logic [31:0] pc, input logic dv, input logic [4:0] d,
                           input logic av, input logic [4:0] a, input logic bv, input logic [4:0] b);
    retirePc = pc; retireDstValid = dv; retireDst = d;
    retireSrcAValid = av; retireSrcA = a; retireSrcBValid = bv; retireSrcB = b;
  endtask

  task automatic setLoopInstr(input int p);
    case (p)
      0: setRetire(32'h100, 1'b1, 5'd1, 1'b1, 5'd2, 1'b0, 5'd0);
      1: setRetire(32'h104, 1'b1, 5'd3, 1'b1, 5'd3, 1'b0, 5'd0);
      2: setRetire(32'h108, 1'b1, 5'd6, 1'b1, 5'd3, 1'b0, 5'd0);
      3: setRetire(32'h10C, 1'b1, 5'd2, 1'b1, 5'd2, 1'b0, 5'd0);
      4: setRetire(32'h110, 1'b1, 5'd1, 1'b1, 5'd4, 1'b1, 5'd1);
      5: setRetire(32'h114, 1'b1, 5'd5, 1'b1, 5'd1, 1'b0, 5'd0);
      6: setRetire(32'h118, 1'b1, 5'd5, 1'b1, 5'd5, 1'b0, 5'd0);
      7: setRetire(32'h11C, 1'b0, 5'd0, 1'b1, 5'd1, 1'b1, 5'd5);
      default: setRetire(32'h120, 1'b0, 5'd0, 1'b1, 5'd6, 1'b0, 5'd0);
    endcase
  endtask

  task automatic pushCurrent();
    retireValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    retireValid = 1'b0;
  endtask

  task automatic pushLoop(input int iters);
    for (int k = 0; k < iters * 9; k++) begin
      setLoopInstr(k % 9);
      pushCurrent();
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Start a build; count rising edges from the start edge to the pulse.
  task automatic runBuild(input logic [31:0] pc, input logic mp, input logic inject,
                          output int lat, output logic gotDone, output logic gotFail,
                          output logic busyAfterStart);
    buildPc = pc; multiPass = mp; buildStart = 1'b1;
    if (inject) begin setLoopInstr(5); retireValid = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    buildStart = 1'b0;
    busyAfterStart = busy;
    lat = 0; gotDone = 1'b0; gotFail = 1'b0;
    for (int w = 0; w < 400; w++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done || fail) begin
        gotDone = done; gotFail = fail;
        break;
      end
    end
    retireValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic gd, gf, bs;
    rstN = 1'b0; retireValid = 1'b0; buildStart = 1'b0; multiPass = 1'b0; buildPc = '0;
    setRetire('0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    @(negedge clk);
    doReset();

    // R9: reset state
    check("R9 busy", {63'd0, busy}, 64'd0);
    check("R9 done", {63'd0, done}, 64'd0);
    check("R9 fail", {63'd0, fail}, 64'd0);
    check("R9 mask", sliceMask, 64'd0);
    check("R9 live", {32'd0, liveIns}, 64'd0);
    check("R9 trig", {58'd0, triggerIdx}, 64'd0);
    // R9/R6: empty buffer fails one cycle after start
    runBuild(32'h114, 1'b0, 1'b0, lat, gd, gf, bs);
    check("R9 empty fail", {63'd0, gf}, 64'd1);
    check("R9 empty latency", 64'(lat), 64'd1);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      pushLoop(int'(VECS[v].iters));
      runBuild(VECS[v].pc, VECS[v].multi, 1'b0, lat, gd, gf, bs);
      check($sformatf("R6 vec%0d fail", v), {63'd0, gf}, {63'd0, VECS[v].isFail});
      check($sformatf("R8 vec%0d done", v), {63'd0, gd}, {63'd0, !VECS[v].isFail});
      check($sformatf("R8 vec%0d latency", v), 64'(lat), 64'(VECS[v].lat));
      check($sformatf("R3 vec%0d mask", v), sliceMask, VECS[v].mask);
      check($sformatf("R4 vec%0d live", v), {32'd0, liveIns}, {32'd0, VECS[v].live});
      check($sformatf("R5 vec%0d trig", v), {58'd0, triggerIdx}, {58'd0, VECS[v].trig});
      if (v == 0) check("R8 busy after start", {63'd0, bs}, 64'd1);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R8 vec%0d pulse ends", v), {62'd0, done, fail}, 64'd0);
      check($sformatf("R7 vec%0d results held", v), sliceMask, VECS[v].mask);
    end

    // R2: retirements during a build and in its start cycle are dropped
    doReset();
    pushLoop(2);
    runBuild(32'h114, 1'b0, 1'b1, lat, gd, gf, bs);
    check("R2 first build trig", {58'd0, triggerIdx}, 64'd5);
    runBuild(32'h114, 1'b0, 1'b0, lat, gd, gf, bs);
    check("R2 second build done", {63'd0, gd}, 64'd1);
    check("R2 second build mask", sliceMask, 64'h6200);
    check("R2 second build trig", {58'd0, triggerIdx}, 64'd5);
    check("R2 second build latency", 64'(lat), 64'd13);

    // R10: invalid source and destination fields
    doReset();
    setRetire(32'h200, 1'b1, 5'd7,  1'b1, 5'd8,  1'b0, 5'd9);  pushCurrent(); // slot 0
    setRetire(32'h204, 1'b1, 5'd9,  1'b1, 5'd10, 1'b0, 5'd0);  pushCurrent(); // slot 1
    setRetire(32'h208, 1'b0, 5'd8,  1'b1, 5'd11, 1'b0, 5'd0);  pushCurrent(); // slot 2
    setRetire(32'h20C, 1'b1, 5'd8,  1'b1, 5'd12, 1'b0, 5'd13); pushCurrent(); // slot 3
    setRetire(32'h200, 1'b1, 5'd7,  1'b1, 5'd8,  1'b0, 5'd9);  pushCurrent(); // slot 4
    runBuild(32'h200, 1'b0, 1'b0, lat, gd, gf, bs);
    check("R10 done", {63'd0, gd}, 64'd1);
    check("R10 mask", sliceMask, 64'h18);
    check("R10 live", {32'd0, liveIns}, 64'h1000);
    check("R10 trig", {58'd0, triggerIdx}, 64'd0);
    check("R10 latency", 64'(lat), 64'd5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

endmodule